// File: doc/BRIEF.md
# Dual-Edge Input Timestamp Latch

This block watches a small group of already-synchronised digital inputs. For every channel it keeps two 64-bit time registers: one holds the time of the latest low-to-high transition and the other holds the time of the latest high-to-low transition. Both values are copied from a free-running system time counter. A status byte per channel shows which captures have happened.

Two capture modes are available. Continuous mode is the default, selected by `single_mode` = 0. In this mode each edge overwrites the matching time register and the status bits stay clear. Single-event mode is selected by `single_mode` = 1. In this mode each time register is written by the first edge of its polarity and then held. A per-channel re-arm strobe opens the register again.

The input levels and the status bytes are sampled on a snapshot strobe that marks the start of a readout. The time registers keep running after that strobe. A combinational read port returns whichever register is selected, including a capture made in the current cycle. As a result, a level taken at the snapshot can disagree with a timestamp read later. Precise pulse analysis should therefore rely on the timestamps.

Top module: `edge_stamp_latch`

## Requirements
- R1: `level` is loaded from `din` on a clock edge where `snap` is 1, and it holds its value on every other edge.
- R2: A rising edge on channel c is a cycle where `din[c]` is 1 and the sample of the previous cycle was 0. A falling edge is the opposite. A captured edge stores the `sys_time` value present in the cycle the edge is detected.
- R3: In continuous mode (`single_mode` = 0), every edge overwrites the time register of its polarity, and the live status bits are cleared on the next clock edge.
- R4: There are four time registers. `rd_sel` selects one of them: 0 is rising on channel 0, 1 is falling on channel 0, 2 is rising on channel 1 and 3 is falling on channel 1.
- R5: In single-event mode, a rising capture sets status bit 0 and a falling capture sets status bit 1. Bits 7:2 are always 0. The status byte of channel c is `status[8c+7:8c]`.
- R6: In single-event mode, while a polarity's status bit is set, further edges of that polarity leave its time register and its status bit unchanged.
- R7: A `rearm[c]` pulse in single-event mode clears both status bits of channel c. The next edge of either polarity is then captured.
- R8: If `rearm[c]` and an edge of channel c arrive in the same cycle, the edge is captured and its status bit stays set.
- R9: After reset, all time registers, `level` and `status` are 0. The previous-sample register loads `din` during reset, so an input held high reports no edge.
- R10: `rd_data` is combinational. It already shows a capture that will be stored at the end of the current cycle.
- R11: On `snap`, `status` takes the status bits as they stood before that cycle's edges. Time registers keep capturing after the snapshot, even when this leaves them inconsistent with the sampled level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sys_time | input | 64 | Free-running system time |
| din | input | 2 | Synchronised channel inputs |
| single_mode | input | 1 | 1 = single-event mode, 0 = continuous mode |
| rearm | input | 2 | Per-channel re-arm strobe |
| snap | input | 1 | Snapshot strobe for level and status |
| rd_sel | input | 2 | Selects the time register to read |
| level | output | 2 | Snapshotted input levels |
| status | output | 16 | Snapshotted status bytes, one byte per channel |
| rd_data | output | 64 | Selected time register |

## Verification
The assertions check four things on every cycle. Continuous-mode edges must store the previous cycle's time. Status bits must set on single-event captures and stay clear in continuous mode. A set bit without a re-arm must freeze its register. An edge that meets a re-arm in the same cycle must win. The bench's scenarios are needed for the rest. They cover the read-select mapping, the combinational visibility of a same-cycle capture, the quiet reset with the inputs held high, and the snapshot's view of status taken before that cycle's edges. They also show a level and a timestamp drifting apart when an edge follows the snapshot.

// File: rtl/edge_stamp_latch.sv
module edge_stamp_latch #(
  parameter int NCH = 2,
  parameter int TW  = 64,
  localparam int NREG = 2 * NCH,
  localparam int SW   = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TW-1:0]     sys_time,
  input  logic [NCH-1:0]    din,
  input  logic              single_mode,
  input  logic [NCH-1:0]    rearm,
  input  logic              snap,
  input  logic [SW-1:0]     rd_sel,
  output logic [NCH-1:0]    level,
  output logic [8*NCH-1:0]  status,
  output logic [TW-1:0]     rd_data
);

  logic [NCH-1:0] prev_q, rise, fall, cap_r, cap_f, st_r, st_f;
  logic [NREG-1:0][TW-1:0] ts_q, ts_now;
  logic [8*NCH-1:0] st_bytes;

  assign rise  = din & ~prev_q;
  assign fall  = ~din & prev_q;
  assign cap_r = rise & (~{NCH{single_mode}} | ~st_r | rearm);
  assign cap_f = fall & (~{NCH{single_mode}} | ~st_f | rearm);

  always_comb begin
    for (int c = 0; c < NCH; c++) begin
      ts_now[2*c]   = cap_r[c] ? sys_time : ts_q[2*c];
      ts_now[2*c+1] = cap_f[c] ? sys_time : ts_q[2*c+1];
      st_bytes[8*c +: 8] = {6'b0, st_f[c], st_r[c]};
    end
  end

  assign rd_data = ts_now[rd_sel];

  always_ff @(posedge clk) prev_q <= din;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ts_q <= '0;
      st_r <= '0;
      st_f <= '0;
    end else begin
      ts_q <= ts_now;
      for (int c = 0; c < NCH; c++) begin
        st_r[c] <= single_mode & (cap_r[c] | (st_r[c] & ~rearm[c]));
        st_f[c] <= single_mode & (cap_f[c] | (st_f[c] & ~rearm[c]));
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      level  <= '0;
      status <= '0;
    end else if (snap) begin
      level  <= din;
      status <= st_bytes;
    end
  end

endmodule

module edge_stamp_latch_chk #(
  parameter int NCH = 2,
  parameter int TW  = 64
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [TW-1:0]             sys_time,
  input logic [NCH-1:0]            din,
  input logic                      single_mode,
  input logic [NCH-1:0]            rearm,
  input logic                      snap,
  input logic [NCH-1:0]            level,
  input logic [NCH-1:0]            st_r,
  input logic [NCH-1:0]            st_f,
  input logic [2*NCH-1:0][TW-1:0]  ts_q
);

  logic [NCH-1:0] d_q;
  logic vld;

  always_ff @(posedge clk) begin
    d_q <= din;
    vld <= rst_n;
  end

  a_r1_level_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !snap |=> $stable(level));

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    a_r3_cont_rise: assert property (@(posedge clk) disable iff (!rst_n)
      vld && !single_mode && din[c] && !d_q[c] |=> ts_q[2*c] == $past(sys_time));
    a_r3_cont_fall: assert property (@(posedge clk) disable iff (!rst_n)
      vld && !single_mode && !din[c] && d_q[c] |=> ts_q[2*c+1] == $past(sys_time));
    a_r3_cont_clear: assert property (@(posedge clk) disable iff (!rst_n)
      !single_mode |=> !st_r[c] && !st_f[c]);
    a_r5_rise_sets: assert property (@(posedge clk) disable iff (!rst_n)
      vld && single_mode && din[c] && !d_q[c] |=> st_r[c]);
    a_r5_fall_sets: assert property (@(posedge clk) disable iff (!rst_n)
      vld && single_mode && !din[c] && d_q[c] |=> st_f[c]);
    a_r6_rise_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      single_mode && st_r[c] && !rearm[c] |=> $stable(ts_q[2*c]) && st_r[c]);
    a_r6_fall_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      single_mode && st_f[c] && !rearm[c] |=> $stable(ts_q[2*c+1]) && st_f[c]);
    a_r8_edge_wins: assert property (@(posedge clk) disable iff (!rst_n)
      vld && single_mode && rearm[c] && din[c] && !d_q[c]
      |=> st_r[c] && ts_q[2*c] == $past(sys_time));
  end

endmodule

bind edge_stamp_latch edge_stamp_latch_chk #(.NCH(NCH), .TW(TW)) u_chk (
  .clk(clk), .rst_n(rst_n), .sys_time(sys_time), .din(din),
  .single_mode(single_mode), .rearm(rearm), .snap(snap), .level(level),
  .st_r(st_r), .st_f(st_f), .ts_q(ts_q)
);

// File: tb/edge_stamp_latch_tb.sv
module edge_stamp_latch_tb;
  logic clk = 0;
  logic rst_n = 0;
  logic [63:0] sys_time = 64'hFFFF_FFFF_FFFF_FE00;
  logic [1:0] din = 2'b11, rearm = 0, rd_sel = 0;
  logic single_mode = 0, snap = 0;
  logic [1:0] level;
  logic [15:0] status;
  logic [63:0] rd_data;

  int checks = 0, errors = 0;
  logic [63:0] m_ts [4];
  logic [1:0] m_prev, m_lvl, m_sr, m_sf;
  logic [15:0] m_stat;
  logic [15:0] lf = 16'hACE1;

  edge_stamp_latch u_dut (.clk(clk), .rst_n(rst_n), .sys_time(sys_time), .din(din),
    .single_mode(single_mode), .rearm(rearm), .snap(snap), .rd_sel(rd_sel),
    .level(level), .status(status), .rd_data(rd_data));

  always #10 clk = ~clk;
  always @(posedge clk) sys_time <= sys_time + 64'd13;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic [1:0] d, input logic m, input logic [1:0] ra, input logic s, input string tag);
    logic [63:0] nts [4];
    logic [1:0] cr, cf;
    din = d; single_mode = m; rearm = ra; snap = s;
    for (int c = 0; c < 2; c++) begin
      cr[c] = d[c] && !m_prev[c] && (!m || !m_sr[c] || ra[c]);
      cf[c] = !d[c] && m_prev[c] && (!m || !m_sf[c] || ra[c]);
      nts[2*c]   = cr[c] ? sys_time : m_ts[2*c];
      nts[2*c+1] = cf[c] ? sys_time : m_ts[2*c+1];
    end
    for (int k = 0; k < 4; k++) begin
      rd_sel = 2'(k);
      #1;
      chk(rd_data === nts[k], tag, rd_data, nts[k]);
    end
    @(posedge clk); #2;
    if (s) begin
      m_lvl = d;
      m_stat = {6'b0, m_sf[1], m_sr[1], 6'b0, m_sf[0], m_sr[0]};
    end
    for (int c = 0; c < 2; c++) begin
      m_sr[c] = m && (cr[c] || (m_sr[c] && !ra[c]));
      m_sf[c] = m && (cf[c] || (m_sf[c] && !ra[c]));
    end
    for (int k = 0; k < 4; k++) m_ts[k] = nts[k];
    m_prev = d;
    chk(level === m_lvl, "R1 level", 64'(level), 64'(m_lvl));
    chk(status === m_stat, {tag, " R11 status"}, 64'(status), 64'(m_stat));
    snap = 0; rearm = 0;
  endtask

  initial begin
    #(20 * 150000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    #2 rst_n = 1;
    for (int k = 0; k < 4; k++) m_ts[k] = 0;
    m_prev = 2'b11; m_lvl = 0; m_sr = 0; m_sf = 0; m_stat = 0;
    chk(level === 2'b00 && status === 16'h0, "R9 reset outputs", {level, status}, 0);
    // R9: input held high through reset gives no edge
    cyc(2'b11, 0, 0, 0, "R9");
    cyc(2'b11, 0, 0, 1, "R9");
    // R3 / R2: continuous overwrites
    cyc(2'b10, 0, 0, 0, "R3");
    cyc(2'b11, 0, 0, 0, "R3");
    cyc(2'b10, 0, 0, 1, "R3");
    cyc(2'b11, 0, 0, 0, "R2");
    // R4: channel 1 only
    cyc(2'b01, 0, 0, 0, "R4");
    cyc(2'b11, 0, 0, 0, "R4");
    // R5 / R6: single-event capture then freeze
    cyc(2'b11, 1, 2'b11, 0, "R7");
    cyc(2'b10, 1, 0, 1, "R5");
    cyc(2'b11, 1, 0, 1, "R5");
    cyc(2'b10, 1, 0, 0, "R6");
    cyc(2'b11, 1, 0, 1, "R6");
    // R7: re-arm then later edge captured
    cyc(2'b11, 1, 2'b01, 1, "R7");
    cyc(2'b10, 1, 0, 1, "R7");
    // R8: re-arm and edge together
    cyc(2'b11, 1, 2'b01, 1, "R8");
    cyc(2'b11, 1, 0, 1, "R8");
    // R10: both channels edge, read in same cycle
    cyc(2'b00, 0, 0, 0, "R10");
    cyc(2'b11, 0, 0, 0, "R10");
    // R11: snapshot low, then a rising edge updates time only
    cyc(2'b00, 0, 0, 1, "R11");
    cyc(2'b01, 0, 0, 0, "R11");
    cyc(2'b01, 1, 0, 0, "R11");
    cyc(2'b00, 1, 0, 0, "R11");
    cyc(2'b01, 1, 0, 1, "R11");
    // Sweep over modes, edges, re-arm and snapshot patterns
    for (int i = 0; i < 4000; i++) begin
      logic m;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      m = (i / 250) % 2 == 1;
      cyc(lf[1:0], m, lf[3:2] & {2{lf[4] & lf[5]}}, lf[6], m ? "R6" : "R2");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule